// File: doc/BRIEF.md
# Bisync Control Character Recognizer

This block sits behind the character assembler of a byte-synchronous receiver on a link that may carry transparent text. For every received 8-bit character it reports which protocol control the character stands for. It also tracks whether the link is idle, inside ordinary text or inside transparent text, and it decides whether the character feeds the block check. A downstream CRC engine uses three outputs and does no framing work of its own: an include flag, a restart pulse for the opening character of a block, and a check pulse on the last received check byte.

Characters arrive on a valid strobe. A code-set select chooses between the two supported character codes. A transparency enable allows a DLE STX pair to open transparent text, where a lone control code is ordinary data and only a character that follows DLE carries control meaning. Gaps between strobes are allowed and change nothing. The number of check bytes that follow a block terminator is a parameter.

Top module: `bsc_ctl_recognizer`

## Requirements
- R1: With `ascii_sel_i`=1 the codes are SOH 0x01, STX 0x02, ETX 0x03, EOT 0x04, ENQ 0x05, DLE 0x10, SYN 0x16, ETB 0x17, ITB 0x1F. With `ascii_sel_i`=0 they are SOH 0x01, STX 0x02, ETX 0x03, DLE 0x10, ITB 0x1F, ETB 0x26, ENQ 0x2D, SYN 0x32, EOT 0x37. `class_o` is one-hot with bit 0 data, 1 SOH, 2 STX, 3 ETX, 4 ETB, 5 ITB, 6 EOT, 7 ENQ, 8 SYN, 9 DLE. `is_ctrl_o` is 1 exactly when bit 0 is clear.
- R2: The results for a character appear on the outputs one clock after its strobe, together with `out_vld_o`=1. `out_vld_o`, `crc_restart_o` and `crc_check_o` are 0 in every cycle that follows a cycle with no strobe.
- R3: Outside a block, every recognised code is reported as a control and any other character as data. Neither is included in the CRC. An ENQ or EOT there is a plain control event with no check pulse.
- R4: An SOH or STX received outside a block opens a block. It raises `crc_restart_o` and is not included in the CRC.
- R5: Inside ordinary text, SYN is reported as a control and excluded from the CRC. Data characters, and an SOH or STX inside the block, are included.
- R6: ETX, ETB or ITB inside a block is a control that is included in the CRC. The next CRC_BYTES characters are check bytes: they are reported as data and included whatever their value, and the last of them raises `crc_check_o`. The block then ends after ETX or ETB, and ordinary text continues after ITB.
- R7: With `transp_en_i`=1, a DLE followed by STX, either outside a block or inside ordinary text, enters transparent text. The DLE is a control excluded from the CRC. STX raises restart when it opens the block and is included when it follows a header. `in_transp_o` is 1 from that STX on and holds between strobes.
- R8: In transparent text, a character not preceded by DLE is data and is included in the CRC, even when its value equals a control code.
- R9: In transparent text, DLE DLE yields one data DLE that is included in the CRC. DLE SYN reports the SYN as a control, and both characters are excluded.
- R10: In transparent text, DLE followed by ETX, ETB or ITB leaves transparency (`in_transp_o`=0 with that character) and R6 applies.
- R11: ENQ or EOT inside ordinary text, or after DLE in transparent text, aborts the block. It is a control, is excluded from the CRC, raises no check pulse and returns the link to idle.
- R12: With `transp_en_i`=0, a DLE outside a block is a control that does not prefix the next character, so a following STX opens ordinary text. A DLE inside ordinary text is data and is included in the CRC.
- R13: Reset clears all outputs to 0 and returns the link to idle, ending any transparent text.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chr_vld_i | input | 1 | Character strobe |
| chr_i | input | 8 | Received character |
| ascii_sel_i | input | 1 | 1 selects the ASCII code set, 0 the EBCDIC code set |
| transp_en_i | input | 1 | Allows DLE STX to open transparent text |
| out_vld_o | output | 1 | Results valid for the character strobed one cycle earlier |
| class_o | output | 10 | One-hot character class (see R1) |
| is_ctrl_o | output | 1 | Character has control meaning |
| crc_incl_o | output | 1 | Character is accumulated into the CRC |
| crc_restart_o | output | 1 | Character opens a block; clear the CRC |
| crc_check_o | output | 1 | Last check byte; compare the CRC now |
| in_transp_o | output | 1 | Link is in transparent text after this character |

## Verification
The bench builds the block with CRC_BYTES at its default of 2, so each check window closes two characters after a terminator. This keeps every transition from idle, through text, transparency and the check trailer, back to idle within a short stream. Check bytes are chosen to equal control codes, which shows that the trailer ignores decoding. The same byte values are sent under both code sets and with transparency enabled and disabled, so each code and each DLE rule is reached in both of its contexts.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int NCLS  = 10;
  localparam int CHR_W = 8;

  typedef enum logic [3:0] {
    C_DATA = 4'd0, C_SOH = 4'd1, C_STX = 4'd2, C_ETX = 4'd3, C_ETB = 4'd4,
    C_ITB  = 4'd5, C_EOT = 4'd6, C_ENQ = 4'd7, C_SYN = 4'd8, C_DLE = 4'd9
  } cls_e;

  typedef enum logic [1:0] {M_IDLE = 2'd0, M_TEXT = 2'd1, M_TRANSP = 2'd2} mode_e;

  function automatic logic [CHR_W-1:0] code_of(input int idx, input logic ascii);
    logic [CHR_W-1:0] c;
    case (idx)
      1:       c = 8'h01;
      2:       c = 8'h02;
      3:       c = 8'h03;
      4:       c = ascii ? 8'h17 : 8'h26;
      5:       c = 8'h1F;
      6:       c = ascii ? 8'h04 : 8'h37;
      7:       c = ascii ? 8'h05 : 8'h2D;
      8:       c = ascii ? 8'h16 : 8'h32;
      9:       c = 8'h10;
      default: c = 8'h00;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/bsc_code_match.sv
module bsc_code_match
  import bsc_pkg::*;
(
  input  logic [CHR_W-1:0] chr_i,
  input  logic             ascii_i,
  output cls_e             idx_o
);
  logic [NCLS-1:0] hit;

  assign hit[0] = ~|hit[NCLS-1:1];
  for (genvar gi = 1; gi < NCLS; gi++) begin : g_cmp
    assign hit[gi] = (chr_i == code_of(gi, ascii_i));
  end

  always_comb begin
    idx_o = C_DATA;
    for (int i = 1; i < NCLS; i++)
      if (hit[i]) idx_o = cls_e'(i);
  end
endmodule

// File: rtl/bsc_trail_cnt.sv
module bsc_trail_cnt #(
  parameter int CRC_BYTES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic step_i,
  output logic busy_o,
  output logic last_o
);
  localparam int CW = $clog2(CRC_BYTES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= CW'(CRC_BYTES);
    else if (step_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
  assign last_o = (cnt_q == CW'(1));

  a_r6_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CRC_BYTES));
  a_r6_no_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  a_r6_step_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && busy_o && !load_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/bsc_seq_ctl.sv
module bsc_seq_ctl
  import bsc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vld_i,
  input  cls_e idx_i,
  input  logic transp_en_i,
  input  logic busy_i,
  input  logic last_i,
  output cls_e cls_o,
  output logic ctrl_o,
  output logic incl_o,
  output logic restart_o,
  output logic check_o,
  output logic load_o,
  output logic transp_o
);
  mode_e mode_q, mode_d;
  logic  pend_q, pend_d;
  logic  is_term, is_abort;

  assign is_term  = (idx_i == C_ETX) || (idx_i == C_ETB) || (idx_i == C_ITB);
  assign is_abort = (idx_i == C_ENQ) || (idx_i == C_EOT);

  always_comb begin
    cls_o = C_DATA; ctrl_o = 1'b0; incl_o = 1'b0; restart_o = 1'b0;
    check_o = 1'b0; load_o = 1'b0; mode_d = mode_q; pend_d = pend_q;
    if (vld_i) begin
      pend_d = 1'b0;
      if (busy_i) begin
        incl_o  = 1'b1;
        check_o = last_i;
      end else begin
        case (mode_q)
          M_IDLE: begin
            cls_o  = idx_i;
            ctrl_o = (idx_i != C_DATA);
            if (pend_q && idx_i == C_STX) begin
              restart_o = 1'b1;
              mode_d    = M_TRANSP;
            end else if (idx_i == C_SOH || idx_i == C_STX) begin
              restart_o = 1'b1;
              mode_d    = M_TEXT;
            end else if (idx_i == C_DLE) begin
              pend_d = transp_en_i;
            end
          end
          M_TEXT: begin
            if (pend_q && idx_i == C_STX) begin
              cls_o = C_STX; ctrl_o = 1'b1; incl_o = 1'b1;
              mode_d = M_TRANSP;
            end else if (is_term) begin
              cls_o = idx_i; ctrl_o = 1'b1; incl_o = 1'b1; load_o = 1'b1;
              mode_d = (idx_i == C_ITB) ? M_TEXT : M_IDLE;
            end else if (is_abort) begin
              cls_o = idx_i; ctrl_o = 1'b1;
              mode_d = M_IDLE;
            end else begin
              case (idx_i)
                C_SYN: begin cls_o = C_SYN; ctrl_o = 1'b1; end
                C_SOH, C_STX: begin cls_o = idx_i; ctrl_o = 1'b1; incl_o = 1'b1; end
                C_DLE: begin
                  if (transp_en_i) begin
                    cls_o = C_DLE; ctrl_o = 1'b1; pend_d = 1'b1;
                  end else begin
                    incl_o = 1'b1;
                  end
                end
                default: incl_o = 1'b1;
              endcase
            end
          end
          M_TRANSP: begin
            if (!pend_q) begin
              if (idx_i == C_DLE) begin
                cls_o = C_DLE; ctrl_o = 1'b1; pend_d = 1'b1;
              end else begin
                incl_o = 1'b1;
              end
            end else if (is_term) begin
              cls_o = idx_i; ctrl_o = 1'b1; incl_o = 1'b1; load_o = 1'b1;
              mode_d = (idx_i == C_ITB) ? M_TEXT : M_IDLE;
            end else if (is_abort) begin
              cls_o = idx_i; ctrl_o = 1'b1;
              mode_d = M_IDLE;
            end else if (idx_i == C_SYN) begin
              cls_o = C_SYN; ctrl_o = 1'b1;
            end else begin
              incl_o = 1'b1;  // DLE DLE and stray follow-ups stand as data
            end
          end
          default: mode_d = M_IDLE;
        endcase
      end
    end
    transp_o = (mode_d == M_TRANSP);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= M_IDLE;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  a_r6_trail_freezes_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> mode_q == $past(mode_q));
  a_r7_pend_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !busy_i && mode_q != M_TRANSP && !transp_en_i) |=> !pend_q);
endmodule

// File: rtl/bsc_ctl_recognizer.sv
module bsc_ctl_recognizer
  import bsc_pkg::*;
#(
  parameter int CRC_BYTES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             chr_vld_i,
  input  logic [CHR_W-1:0] chr_i,
  input  logic             ascii_sel_i,
  input  logic             transp_en_i,
  output logic             out_vld_o,
  output logic [NCLS-1:0]  class_o,
  output logic             is_ctrl_o,
  output logic             crc_incl_o,
  output logic             crc_restart_o,
  output logic             crc_check_o,
  output logic             in_transp_o
);
  localparam logic [NCLS-1:0] ONE     = {{(NCLS-1){1'b0}}, 1'b1};
  localparam logic [NCLS-1:0] END_MSK = (ONE << C_ETX) | (ONE << C_ETB) | (ONE << C_ITB)
                                      | (ONE << C_ENQ) | (ONE << C_EOT);

  cls_e idx, cls_c;
  logic ctrl_c, incl_c, rst_c, chk_c, load_c, transp_c, busy, last;

  bsc_code_match u_match (
    .chr_i  (chr_i),
    .ascii_i(ascii_sel_i),
    .idx_o  (idx)
  );

  bsc_trail_cnt #(.CRC_BYTES(CRC_BYTES)) u_trail (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load_c),
    .step_i(chr_vld_i & busy),
    .busy_o(busy),
    .last_o(last)
  );

  bsc_seq_ctl u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vld_i      (chr_vld_i),
    .idx_i      (idx),
    .transp_en_i(transp_en_i),
    .busy_i     (busy),
    .last_i     (last),
    .cls_o      (cls_c),
    .ctrl_o     (ctrl_c),
    .incl_o     (incl_c),
    .restart_o  (rst_c),
    .check_o    (chk_c),
    .load_o     (load_c),
    .transp_o   (transp_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_o     <= 1'b0;
      class_o       <= '0;
      is_ctrl_o     <= 1'b0;
      crc_incl_o    <= 1'b0;
      crc_restart_o <= 1'b0;
      crc_check_o   <= 1'b0;
      in_transp_o   <= 1'b0;
    end else begin
      out_vld_o     <= chr_vld_i;
      crc_restart_o <= chr_vld_i & rst_c;
      crc_check_o   <= chr_vld_i & chk_c;
      if (chr_vld_i) begin
        class_o     <= ONE << cls_c;
        is_ctrl_o   <= ctrl_c;
        crc_incl_o  <= incl_c;
        in_transp_o <= transp_c;
      end
    end
  end

  a_r1_class_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> $onehot(class_o));
  a_r1_ctrl_vs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_vld_o |-> (is_ctrl_o == !class_o[C_DATA]));
  a_r2_pulses_need_vld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_vld_o |-> !crc_check_o && !crc_restart_o);
  a_r4_restart_excluded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_restart_o |-> !crc_incl_o && is_ctrl_o);
  a_r6_check_on_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    crc_check_o |-> crc_incl_o && class_o[C_DATA]);
  a_r7_enter_on_stx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_transp_o) |-> out_vld_o && class_o[C_STX]);
  a_r10_leave_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(in_transp_o) |-> out_vld_o && (class_o & END_MSK) != '0);
  a_r7_hold_in_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chr_vld_i |=> $stable(in_transp_o));
endmodule

// File: tb/sim_bsc_ctl_recognizer.sv
module sim_bsc_ctl_recognizer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       vld = 1'b0, asc = 1'b1, ten = 1'b1;
  logic [7:0] chr = 8'h00;
  logic       out_vld, ctrl, incl, crst, chk, tr;
  logic [9:0] cls;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  bsc_ctl_recognizer #(.CRC_BYTES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .chr_vld_i(vld), .chr_i(chr),
    .ascii_sel_i(asc), .transp_en_i(ten), .out_vld_o(out_vld), .class_o(cls),
    .is_ctrl_o(ctrl), .crc_incl_o(incl), .crc_restart_o(crst),
    .crc_check_o(chk), .in_transp_o(tr)
  );

  // {req[28:25], ascii[24], transp_en[23], chr[22:15], class[14:5], ctrl,incl,restart,check,transp}
  localparam int NV = 53;
  localparam logic [28:0] VEC [NV] = '{
    {4'd3, 2'b11, 8'h16, 10'h100, 5'b10000},  // R3 idle SYN
    {4'd3, 2'b11, 8'h41, 10'h001, 5'b00000},  // R3 idle data
    {4'd3, 2'b11, 8'h05, 10'h080, 5'b10000},  // R3 idle ENQ
    {4'd4, 2'b11, 8'h01, 10'h002, 5'b10100},  // R4 SOH opens
    {4'd5, 2'b11, 8'h48, 10'h001, 5'b01000},  // R5
    {4'd5, 2'b11, 8'h02, 10'h004, 5'b11000},  // R5 STX after header
    {4'd5, 2'b11, 8'h16, 10'h100, 5'b10000},  // R5 SYN excluded
    {4'd5, 2'b11, 8'h44, 10'h001, 5'b01000},  // R5
    {4'd6, 2'b11, 8'h1F, 10'h020, 5'b11000},  // R6 ITB
    {4'd6, 2'b11, 8'h03, 10'h001, 5'b01000},  // R6 check byte = ETX code
    {4'd6, 2'b11, 8'h10, 10'h001, 5'b01010},  // R6 last check byte
    {4'd6, 2'b11, 8'h45, 10'h001, 5'b01000},  // R6 text resumes after ITB
    {4'd6, 2'b11, 8'h17, 10'h010, 5'b11000},  // R6 ETB
    {4'd6, 2'b11, 8'h05, 10'h001, 5'b01000},  // R6
    {4'd6, 2'b11, 8'h16, 10'h001, 5'b01010},  // R6
    {4'd3, 2'b11, 8'h04, 10'h040, 5'b10000},  // R3 idle EOT
    {4'd7, 2'b11, 8'h10, 10'h200, 5'b10000},  // R7 DLE
    {4'd7, 2'b11, 8'h02, 10'h004, 5'b10101},  // R7 STX enters
    {4'd8, 2'b11, 8'h03, 10'h001, 5'b01001},  // R8 lone ETX is data
    {4'd8, 2'b11, 8'h16, 10'h001, 5'b01001},  // R8 lone SYN is data
    {4'd9, 2'b11, 8'h10, 10'h200, 5'b10001},  // R9
    {4'd9, 2'b11, 8'h10, 10'h001, 5'b01001},  // R9 DLE DLE
    {4'd9, 2'b11, 8'h10, 10'h200, 5'b10001},  // R9
    {4'd9, 2'b11, 8'h16, 10'h100, 5'b10001},  // R9 DLE SYN
    {4'd9, 2'b11, 8'h78, 10'h001, 5'b01001},  // R9
    {4'd10, 2'b11, 8'h10, 10'h200, 5'b10001}, // R10
    {4'd10, 2'b11, 8'h17, 10'h010, 5'b11000}, // R10 DLE ETB leaves
    {4'd10, 2'b11, 8'h10, 10'h001, 5'b01000}, // R10
    {4'd10, 2'b11, 8'h02, 10'h001, 5'b01010}, // R10
    {4'd1, 2'b01, 8'h02, 10'h004, 5'b10100},  // R1 EBCDIC STX
    {4'd1, 2'b01, 8'h17, 10'h001, 5'b01000},  // R1 0x17 is data in EBCDIC
    {4'd1, 2'b01, 8'h32, 10'h100, 5'b10000},  // R1 EBCDIC SYN
    {4'd11, 2'b01, 8'h2D, 10'h080, 5'b10000}, // R11 ENQ aborts text
    {4'd1, 2'b01, 8'h37, 10'h040, 5'b10000},  // R1 EBCDIC EOT
    {4'd7, 2'b01, 8'h10, 10'h200, 5'b10000},  // R7
    {4'd7, 2'b01, 8'h02, 10'h004, 5'b10101},  // R7
    {4'd7, 2'b01, 8'h10, 10'h200, 5'b10001},  // R7
    {4'd11, 2'b01, 8'h37, 10'h040, 5'b10000}, // R11 DLE EOT aborts
    {4'd12, 2'b10, 8'h10, 10'h200, 5'b10000}, // R12 DLE no prefix
    {4'd12, 2'b10, 8'h02, 10'h004, 5'b10100}, // R12 plain text opens
    {4'd12, 2'b10, 8'h10, 10'h001, 5'b01000}, // R12 DLE is data
    {4'd6, 2'b10, 8'h03, 10'h008, 5'b11000},  // R6 ETX
    {4'd6, 2'b10, 8'h04, 10'h001, 5'b01000},  // R6
    {4'd6, 2'b10, 8'h01, 10'h001, 5'b01010},  // R6
    {4'd7, 2'b11, 8'h01, 10'h002, 5'b10100},  // R7 header
    {4'd7, 2'b11, 8'h10, 10'h200, 5'b10000},  // R7
    {4'd7, 2'b11, 8'h02, 10'h004, 5'b11001},  // R7 STX after header included
    {4'd7, 2'b11, 8'h10, 10'h200, 5'b10001},  // R7
    {4'd10, 2'b11, 8'h1F, 10'h020, 5'b11000}, // R10 DLE ITB
    {4'd10, 2'b11, 8'h1F, 10'h001, 5'b01000}, // R10
    {4'd10, 2'b11, 8'h37, 10'h001, 5'b01010}, // R10
    {4'd6, 2'b11, 8'h7A, 10'h001, 5'b01000},  // R6 plain text after ITB
    {4'd11, 2'b11, 8'h04, 10'h040, 5'b10000}  // R11 EOT aborts text
  };

  function automatic logic [14:0] got_v();
    return {cls, ctrl, incl, crst, chk, tr};
  endfunction

  task automatic check(input string req, input logic [14:0] act, input logic [14:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic a, input logic t, input logic [7:0] c);
    @(negedge clk);
    asc = a; ten = t; chr = c; vld = 1'b1;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R13 reset state
    check("R13 reset outputs", {out_vld, got_v()}[14:0], 15'h0);
    check("R13 reset vld", {14'h0, out_vld}, 15'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][24], VEC[i][23], VEC[i][22:15]);
      @(negedge clk);
      vld = 1'b0;
      n_run++;
      if (!out_vld || got_v() !== VEC[i][14:0]) begin
        n_fail++;
        $display("FAIL R%0d vec %0d actual=%b/%h expected=1/%h",
                 VEC[i][28:25], i, out_vld, got_v(), VEC[i][14:0]);
      end
    end

    // R2 gap cycle: no valid, no pulses
    @(negedge clk);
    check("R2 idle gap", {12'h0, out_vld, crst, chk}, 15'h0);

    // R2 back-to-back latency: SOH then data on consecutive strobes
    drive(1'b1, 1'b1, 8'h01);
    @(negedge clk);
    check("R2 b2b first", {out_vld, cls, ctrl, incl, crst, chk}, {1'b1, 10'h002, 4'b1010});
    chr = 8'h41;
    @(negedge clk);
    vld = 1'b0;
    check("R2 b2b second", {out_vld, cls, ctrl, incl, crst, chk}, {1'b1, 10'h001, 4'b0100});
    @(negedge clk);
    check("R2 pulse clears", {12'h0, out_vld, crst, chk}, 15'h0);

    // R7 transparency held across gaps, then R13 reset ends it
    drive(1'b1, 1'b1, 8'h10);
    @(negedge clk); vld = 1'b0;
    drive(1'b1, 1'b1, 8'h10);   // DLE DLE inside text -> second prefix pend? no: text DLE then DLE again
    @(negedge clk); vld = 1'b0;
    drive(1'b1, 1'b1, 8'h02);
    @(negedge clk); vld = 1'b0;
    check("R7 enters from text", {14'h0, tr}, 15'h1);
    repeat (3) @(negedge clk);
    check("R7 held in gap", {14'h0, tr}, 15'h1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R13 reset ends transparency", {13'h0, tr, out_vld}, 15'h0);
    rst_n = 1'b1;
    drive(1'b1, 1'b1, 8'h03);   // ETX after reset: idle control, not data
    @(negedge clk); vld = 1'b0;
    check("R13 idle after reset", got_v(), {10'h008, 5'b10000});

    done = 1'b1;
    finish_run();
  end
endmodule